// File: doc/BRIEF.md
# Transmitter Reset Sequencer

This block orders the reset of one serial transmit channel. A sequence begins when the chip-level configuration reset is released, when the PLL power-down input falls from high to low, or when an external reset pulse arrives. The external pulse may come from any clock domain. The sequencer first holds in a wait state until the PLL reports lock. It then keeps the channel's internal reset asserted for a fixed number of cycles.

Some output clock divider settings need an extra step. For those settings the sequencer drives a three-interval pulse on a test control bit. Last, it counts an initialization interval, raises a reset-done flag and goes idle. Any new trigger drops the done flag and starts the sequence again from the wait state. All interval lengths are parameters, so a bench can shorten them.

Top module: `txrst_seq`

## Requirements
- R1: While `cfg_rst` is high, and in the first cycle after it is released, `tx_rst` is 1, `test_bit` is 0 and `rst_done` is 0.
- R2: In the wait state, when `pll_lock` is low, the block stays there with `tx_rst` 1, `test_bit` 0 and `rst_done` 0.
- R3: Take the first rising edge at which `pll_lock` is seen high in the wait state. `tx_rst` then stays 1 for RST_CYC more cycles and falls after that.
- R4: When `div_sel` is 1 (divide by 2) or 2 (divide by 4) at the end of the reset phase, `test_bit` is 0 for PH_CYC cycles, then 1 for PH_CYC cycles, then 0 for PH_CYC cycles.
- R5: When `div_sel` is 0 (divide by 1) or 3 (divide by 8), the test interval is skipped and `test_bit` stays 0.
- R6: An initialization interval of INIT_CYC cycles follows. `rst_done` then rises, and it stays high while no trigger arrives.
- R7: A high-to-low transition of `pll_pd` restarts the sequence. At the next rising edge the block is back in the wait state with `rst_done` 0.
- R8: `ext_rst_a` passes through a two-flop synchronizer. A pulse restarts the sequence within three rising edges. While the pulse is held high, the block stays in the wait state even when the PLL is locked.
- R9: A trigger in any state, including the middle of the test interval, restarts the sequence. The following sequence has full-length timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sequencer clock |
| cfg_rst | input | 1 | Synchronous active-high configuration reset; its release starts a sequence |
| pll_pd | input | 1 | PLL power-down; a falling edge restarts the sequence |
| ext_rst_a | input | 1 | Asynchronous external reset pulse |
| pll_lock | input | 1 | PLL lock detect |
| div_sel | input | 2 | Output divider code: 0=/1, 1=/2, 2=/4, 3=/8 |
| tx_rst | output | 1 | Internal channel reset, high in the wait and reset phases |
| test_bit | output | 1 | Test control bit pulse |
| rst_done | output | 1 | Sequence complete |

## Verification
The reference point for all timing is the rising edge at which lock is first seen. After k further edges, `tx_rst` must still be high exactly while k < RST_CYC. `test_bit` must be high exactly while k lies in [RST_CYC+PH_CYC, RST_CYC+2·PH_CYC), and only for the two divider codes that need the pulse. `rst_done` must be high from k = RST_CYC + (3·PH_CYC when the pulse runs) + INIT_CYC onward. The bench compares all three outputs against these formulas at every falling edge, for all four divider codes. Trigger effects are checked as follows:
- power-down triggers are checked at the falling edge after the edge that sees them;
- external pulses are checked three edges after they are driven, which covers the synchronizer delay.

// File: rtl/txrst_pkg.sv
package txrst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_RST  = 3'd2,
        ST_TLO1 = 3'd3,
        ST_THI  = 3'd4,
        ST_TLO2 = 3'd5,
        ST_INIT = 3'd6
    } seq_state_t;

    localparam logic [1:0] DIV_1 = 2'd0;
    localparam logic [1:0] DIV_2 = 2'd1;
    localparam logic [1:0] DIV_4 = 2'd2;
    localparam logic [1:0] DIV_8 = 2'd3;

    // Divider codes that need the test-bit interval
    function automatic logic needs_test_pulse(input logic [1:0] code);
        return (code == DIV_2) || (code == DIV_4);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/txrst_sync.sv
module txrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din_a,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din_a};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/txrst_trig.sv
module txrst_trig (
    input  logic clk,
    input  logic rst,
    input  logic pll_pd,
    input  logic ext_rst_a,
    output logic trig
);
    logic pd_q;
    logic ext_s;

    txrst_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din_a (ext_rst_a),
        .dout  (ext_s)
    );

    always_ff @(posedge clk) begin
        if (rst) pd_q <= 1'b0;
        else     pd_q <= pll_pd;
    end

    assign trig = (pd_q & ~pll_pd) | ext_s;

    // R7: a power-down fall is always reported as a trigger
    assert_pd_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (pd_q && !pll_pd) |-> trig);
endmodule

// File: rtl/txrst_fsm.sv
module txrst_fsm
    import txrst_pkg::*;
#(
    parameter int RST_CYC  = 1024,
    parameter int PH_CYC   = 256,
    parameter int INIT_CYC = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  logic       pll_lock,
    input  logic [1:0] div_sel,
    output logic       tx_rst,
    output logic       test_bit,
    output logic       rst_done
);
    localparam int CNT_MAX = max3(RST_CYC, PH_CYC, INIT_CYC);
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] PH_LAST   = CW'(PH_CYC - 1);
    localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYC - 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst || trig) begin
            state  <= ST_WAIT;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: cnt <= '0;
                ST_WAIT: if (pll_lock) begin
                    state <= ST_RST;
                    cnt   <= '0;
                end
                ST_RST: if (cnt == RST_LAST) begin
                    cnt   <= '0;
                    state <= needs_test_pulse(div_sel) ? ST_TLO1 : ST_INIT;
                end else cnt <= cnt + 1'b1;
                ST_TLO1: if (cnt == PH_LAST) begin
                    cnt <= '0; state <= ST_THI;
                end else cnt <= cnt + 1'b1;
                ST_THI: if (cnt == PH_LAST) begin
                    cnt <= '0; state <= ST_TLO2;
                end else cnt <= cnt + 1'b1;
                ST_TLO2: if (cnt == PH_LAST) begin
                    cnt <= '0; state <= ST_INIT;
                end else cnt <= cnt + 1'b1;
                ST_INIT: if (cnt == INIT_LAST) begin
                    cnt    <= '0;
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end else cnt <= cnt + 1'b1;
                default: state <= ST_WAIT;
            endcase
        end
    end

    assign tx_rst   = (state == ST_WAIT) || (state == ST_RST);
    assign test_bit = (state == ST_THI);
    assign rst_done = done_q;

    // R2: no progress without lock
    assert_wait_lock_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !pll_lock && !trig) |=> (state == ST_WAIT));
    // R3: reset phase leaves only after the full count
    assert_rst_len_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RST && !trig && cnt != RST_LAST) |=> (state == ST_RST));
    // R6: done only rises out of the initialization phase
    assert_done_src_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_done) |-> ($past(state) == ST_INIT));
    // R6: done and internal reset never overlap
    assert_done_excl_R6: assert property (@(posedge clk) disable iff (rst)
        rst_done |-> !tx_rst);
    // R9: any trigger returns to wait with done cleared
    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        trig |=> (state == ST_WAIT && !rst_done));
endmodule

// File: rtl/txrst_seq.sv
module txrst_seq #(
    parameter int RST_CYC  = 1024,
    parameter int PH_CYC   = 256,
    parameter int INIT_CYC = 256
) (
    input  logic       clk,
    input  logic       cfg_rst,
    input  logic       pll_pd,
    input  logic       ext_rst_a,
    input  logic       pll_lock,
    input  logic [1:0] div_sel,
    output logic       tx_rst,
    output logic       test_bit,
    output logic       rst_done
);
    logic trig;

    txrst_trig u_trig (
        .clk       (clk),
        .rst       (cfg_rst),
        .pll_pd    (pll_pd),
        .ext_rst_a (ext_rst_a),
        .trig      (trig)
    );

    txrst_fsm #(
        .RST_CYC  (RST_CYC),
        .PH_CYC   (PH_CYC),
        .INIT_CYC (INIT_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst      (cfg_rst),
        .trig     (trig),
        .pll_lock (pll_lock),
        .div_sel  (div_sel),
        .tx_rst   (tx_rst),
        .test_bit (test_bit),
        .rst_done (rst_done)
    );

    // R5: pulse never appears while the internal reset is asserted
    assert_test_excl_R5: assert property (@(posedge clk) disable iff (cfg_rst)
        test_bit |-> !tx_rst && !rst_done);
endmodule

// File: tb/txrst_seq_tb.sv
module txrst_seq_tb;
    localparam int RC = 16;
    localparam int PC = 4;
    localparam int IC = 8;

    logic clk = 1'b0;
    logic cfg_rst = 1'b1;
    logic pll_pd = 1'b0;
    logic ext_rst_a = 1'b0;
    logic pll_lock = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic tx_rst, test_bit, rst_done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    txrst_seq #(.RST_CYC(RC), .PH_CYC(PC), .INIT_CYC(IC)) u_dut (
        .clk(clk), .cfg_rst(cfg_rst), .pll_pd(pll_pd), .ext_rst_a(ext_rst_a),
        .pll_lock(pll_lock), .div_sel(div_sel),
        .tx_rst(tx_rst), .test_bit(test_bit), .rst_done(rst_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_wait(input string req);
        check(tx_rst == 1'b1, {req, " tx_rst"}, tx_rst, 1);
        check(test_bit == 1'b0, {req, " test_bit"}, test_bit, 0);
        check(rst_done == 1'b0, {req, " rst_done"}, rst_done, 0);
    endtask

    // Precondition: block in wait state, pll_lock low
    task automatic run_seq(input logic [1:0] div);
        bit pulse;
        int total;
        pulse = (div == 2'd1) || (div == 2'd2);
        total = RC + (pulse ? 3 * PC : 0) + IC;
        div_sel = div;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_wait("R2");
        end
        pll_lock = 1'b1;
        @(posedge clk);
        for (int k = 0; k < total + 4; k++) begin
            bit e_rst, e_tb, e_dn;
            @(negedge clk);
            e_rst = (k < RC);
            e_tb  = pulse && (k >= RC + PC) && (k < RC + 2 * PC);
            e_dn  = (k >= total);
            if (tx_rst !== e_rst) check(1'b0, "R3 tx_rst", tx_rst, e_rst);
            if (test_bit !== e_tb) check(1'b0, pulse ? "R4 test_bit" : "R5 test_bit", test_bit, e_tb);
            if (rst_done !== e_dn) check(1'b0, "R6 rst_done", rst_done, e_dn);
        end
        check(1'b1, "R3 window", 0, 0);
        check(rst_done == 1'b1, "R6 done held", rst_done, 1);
        pll_lock = 1'b0;
        repeat (3) @(negedge clk);
        check(rst_done == 1'b1 && !tx_rst, "R6 idle stable", rst_done, 1);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_wait("R1 in reset");
        cfg_rst = 1'b0;
        @(negedge clk);
        check_wait("R1 after release");

        // R3 R4 R5 R6: sweep every divider code
        for (int d = 0; d < 4; d++) begin
            if (d != 0) begin
                pll_pd = 1'b1;
                @(negedge clk);
                pll_pd = 1'b0;
                @(negedge clk);
                check_wait("R7 pd fall");
            end
            run_seq(2'(d));
        end

        // R7: holding power-down high causes no restart
        pll_pd = 1'b1;
        repeat (4) @(negedge clk);
        check(rst_done == 1'b1, "R7 pd high no effect", rst_done, 1);
        pll_pd = 1'b0;
        @(negedge clk);
        check_wait("R7 fall restarts");
        run_seq(2'd3);

        // R8: async pulse, held while lock is high
        ext_rst_a = 1'b1;
        repeat (3) @(negedge clk);
        check_wait("R8 sync trigger");
        pll_lock = 1'b1;
        repeat (8) @(negedge clk);
        check_wait("R8 held in wait");
        pll_lock = 1'b0;
        ext_rst_a = 1'b0;
        repeat (3) @(negedge clk);
        run_seq(2'd1);

        // R8: short pulse of one reference period
        ext_rst_a = 1'b1;
        @(negedge clk);
        ext_rst_a = 1'b0;
        repeat (3) @(negedge clk);
        check_wait("R8 short pulse");
        run_seq(2'd0);

        // R9: restart in the middle of the test-bit high interval
        pll_pd = 1'b1;
        @(negedge clk);
        pll_pd = 1'b0;
        @(negedge clk);
        div_sel = 2'd2;
        pll_lock = 1'b1;
        @(posedge clk);
        repeat (RC + PC + 2) @(negedge clk);
        check(test_bit == 1'b1, "R9 mid pulse", test_bit, 1);
        pll_lock = 1'b0;
        pll_pd = 1'b1;
        @(negedge clk);
        pll_pd = 1'b0;
        @(negedge clk);
        check_wait("R9 restart");
        run_seq(2'd2);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule